// File: doc/BRIEF.md
# Dual Frame Buffer with Client Ownership Handoff

This block holds two frame stores that a pixel producer and a frame consumer share. The producer always writes into one store, chosen by a one-bit selector. The other store holds the most recent completed frame. That completed frame is owned either by the consumer or by the producer. At each frame boundary the stores exchange roles only if the producer owns the completed store at that moment. The exchange hands the new completed frame to the consumer. If the consumer is still holding the completed store, nothing is exchanged and the producer fills its current store again.

Each store carries a 32-bit timestamp. At every frame boundary the producer presents the start time of the new integration period. The store about to be filled is tagged with the midpoint between that time and the previous integration start. The consumer sees a ready flag, which is the ownership flag itself. It returns the store with a release pulse. It reads pixels and the timestamp of the completed store only; reads never touch the store being written.

The ownership controller has two states. In PRODUCER_OWNS, a frame boundary takes the HANDOFF transition to CLIENT_OWNS. In CLIENT_OWNS there are three cases. A release alone takes the GIVE_BACK transition to PRODUCER_OWNS. A frame boundary without a release takes the OVERWRITE self-loop, with no exchange. A release together with a frame boundary takes the RELEASE_HANDOFF self-loop, which does exchange the stores.

Top module: `ping_pong_frame_buffer`

## Requirements
- R1: After reset the producer owns the completed store: `client_ready` is 0, `prod_sel` is 0, `stable_ts` is 0, `rd_data` is 0, and the remembered previous integration start is 0. `prod_sel` changes only in the cycle after a `frame_start`.
- R2: A `frame_start` while `client_ready` is 0 toggles `prod_sel` and sets `client_ready` to 1. Both changes are visible after that clock edge.
- R3: A `frame_start` while `client_ready` is 1 and `release_req` is 0 leaves `prod_sel` and `client_ready` unchanged. Later writes overwrite the producer's current store, and the completed store is not modified.
- R4: `client_ready` goes from 1 to 0 only on a clock edge where `release_req` is 1. It goes from 0 to 1 only on a `frame_start`. A `release_req` while `client_ready` is 0 has no effect.
- R5: A write with `wr_en`=1 stores `wr_data` at `wr_idx` in the store named by `prod_sel`. `rd_data` returns the word at `rd_idx` of the other store, one clock after `rd_idx` is presented.
- R6: On a `frame_start` carrying integration start T, the store the producer fills next (after the exchange decision) is tagged with (P + T) >> 1, where P is the previous start time. The sum is formed at 33 bits, so no carry is lost. P then becomes T. `stable_ts` shows the tag of the store not named by `prod_sel`.
- R7: A read with `rd_idx` of 1546 or more returns 0.
- R8: When `release_req` and `frame_start` are both 1 while `client_ready` is 1, the release is applied first. The stores are exchanged (`prod_sel` toggles) and `client_ready` stays 1.
- R9: Each store holds 1546 pixels of 8 bits at indices 0 to 1545, with storage rounded up to 1548 entries. Every index keeps its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame boundary pulse from the producer |
| integ_start | input | 32 | Start time of the new integration period, valid with `frame_start` |
| wr_en | input | 1 | Pixel write strobe |
| wr_idx | input | 11 | Pixel index to write |
| wr_data | input | 8 | Pixel value to write |
| release_req | input | 1 | Consumer returns the completed store |
| client_ready | output | 1 | Consumer owns the completed store |
| prod_sel | output | 1 | Store the producer is writing (0 or 1) |
| rd_idx | input | 11 | Pixel index to read from the completed store |
| rd_data | output | 8 | Pixel value read, one cycle after `rd_idx` |
| stable_ts | output | 32 | Midpoint timestamp of the completed store |

## Verification
The ownership sequence is driven through a fixed vector list. The list covers a handoff from the producer and an overwrite while the consumer holds the store. It also covers a release alone, a release sent when the producer already owns the store, and a release arriving together with a frame boundary. Each of these is visible as a different combination of `client_ready` and `prod_sel` after the edge. The same list supplies integration start times near the top of the 32-bit range, so a midpoint that loses its carry bit shows up as a wrong `stable_ts`. Pixel tests fill one store with an index-dependent pattern, hand it over, and read it back at the first, middle and last indices and beyond the end. The data path is then checked with an overwrite-without-exchange followed by an exchange. This shows whether the written values went into the producer's store rather than the consumer's.

// File: rtl/pp_frame_pkg.sv
package pp_frame_pkg;

    // Ownership of the completed store
    typedef enum logic {
        PRODUCER_OWNS = 1'b0,
        CLIENT_OWNS   = 1'b1
    } owner_e;

endpackage

// File: rtl/pp_owner_fsm.sv
module pp_owner_fsm
    import pp_frame_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic release_req,
    output logic client_ready,
    output logic prod_sel,
    output logic sel_next
);

    owner_e state_q, state_d;
    logic   sel_q, sel_d;

    // Next-state and transition selection
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            PRODUCER_OWNS: begin
                if (frame_start) begin          // HANDOFF
                    state_d = CLIENT_OWNS;
                    sel_d   = ~sel_q;
                end
            end
            CLIENT_OWNS: begin
                if (release_req && frame_start) begin   // RELEASE_HANDOFF
                    state_d = CLIENT_OWNS;
                    sel_d   = ~sel_q;
                end else if (release_req) begin         // GIVE_BACK
                    state_d = PRODUCER_OWNS;
                end else if (frame_start) begin         // OVERWRITE
                    state_d = CLIENT_OWNS;
                end
            end
            default: state_d = PRODUCER_OWNS;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PRODUCER_OWNS;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // Outputs
    always_comb begin
        client_ready = (state_q == CLIENT_OWNS);
        prod_sel     = sel_q;
        sel_next     = sel_d;
    end

endmodule

// File: rtl/pp_stamp_regs.sv
module pp_stamp_regs #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic [TS_W-1:0] integ_start,
    input  logic            dest_sel,
    input  logic            stable_sel,
    output logic [TS_W-1:0] stable_ts
);

    localparam int SUM_W = TS_W + 1;

    logic [TS_W-1:0]  prev_start_q;
    logic [SUM_W-1:0] sum_w;
    logic [TS_W-1:0]  mid_w;
    logic [TS_W-1:0]  tag_q [2];

    // Midpoint formed one bit wider so the carry survives the shift
    always_comb begin
        sum_w = {1'b0, prev_start_q} + {1'b0, integ_start};
        mid_w = sum_w[SUM_W-1:1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_start_q <= '0;
        end else if (frame_start) begin
            prev_start_q <= integ_start;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_tag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[g] <= '0;
            end else if (frame_start && (dest_sel == 1'(g))) begin
                tag_q[g] <= mid_w;
            end
        end
    end

    assign stable_ts = tag_q[stable_sel];

endmodule

// File: rtl/pp_pixel_store.sv
module pp_pixel_store #(
    parameter int PIX_W     = 8,
    parameter int PIX_COUNT = 1546,
    parameter int DEPTH     = 1548,
    parameter int AW        = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [AW-1:0]    wr_idx,
    input  logic [PIX_W-1:0] wr_data,
    input  logic             rd_bank,
    input  logic [AW-1:0]    rd_idx,
    output logic [PIX_W-1:0] rd_data
);

    localparam logic [AW-1:0] DEPTH_L = AW'(DEPTH);
    localparam logic [AW-1:0] COUNT_L = AW'(PIX_COUNT);

    logic [PIX_W-1:0] word_q [2];
    logic             bank_q;
    logic             oob_q;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [PIX_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(g)) && (wr_idx < DEPTH_L)) begin
                mem[wr_idx] <= wr_data;
            end
            if (rd_idx < DEPTH_L) begin
                word_q[g] <= mem[rd_idx];
            end else begin
                word_q[g] <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
            oob_q  <= 1'b1;
        end else begin
            bank_q <= rd_bank;
            oob_q  <= (rd_idx >= COUNT_L);
        end
    end

    assign rd_data = oob_q ? '0 : word_q[bank_q];

endmodule

// File: rtl/ping_pong_frame_buffer.sv
module ping_pong_frame_buffer #(
    parameter int PIX_W     = 8,
    parameter int PIX_COUNT = 1546,
    parameter int TS_W      = 32,
    localparam int DEPTH    = ((PIX_COUNT + 3) / 4) * 4,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [TS_W-1:0]  integ_start,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [PIX_W-1:0] wr_data,
    input  logic             release_req,
    output logic             client_ready,
    output logic             prod_sel,
    input  logic [AW-1:0]    rd_idx,
    output logic [PIX_W-1:0] rd_data,
    output logic [TS_W-1:0]  stable_ts
);

    logic sel_next;

    pp_owner_fsm u_owner (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .release_req  (release_req),
        .client_ready (client_ready),
        .prod_sel     (prod_sel),
        .sel_next     (sel_next)
    );

    pp_stamp_regs #(.TS_W(TS_W)) u_stamp (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .integ_start (integ_start),
        .dest_sel    (sel_next),
        .stable_sel  (~prod_sel),
        .stable_ts   (stable_ts)
    );

    pp_pixel_store #(
        .PIX_W     (PIX_W),
        .PIX_COUNT (PIX_COUNT),
        .DEPTH     (DEPTH),
        .AW        (AW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bank (prod_sel),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_bank (~prod_sel),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/pp_frame_checker.sv
module pp_frame_checker #(
    parameter int PIX_W     = 8,
    parameter int PIX_COUNT = 1546,
    parameter int AW        = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             release_req,
    input logic             client_ready,
    input logic             prod_sel,
    input logic [AW-1:0]    rd_idx,
    input logic [PIX_W-1:0] rd_data
);

    localparam logic [AW-1:0] COUNT_L = AW'(PIX_COUNT);

    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(prod_sel)); // R1

    AST_HANDOFF_SWAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !client_ready) |=> (client_ready && (prod_sel != $past(prod_sel)))); // R2

    AST_HELD_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && client_ready && !release_req) |=> (client_ready && $stable(prod_sel))); // R3

    AST_GIVE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (client_ready && release_req && !frame_start) |=> !client_ready); // R4

    AST_NO_SPURIOUS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!client_ready && !frame_start) |=> !client_ready); // R4

    AST_KEEP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (client_ready && !release_req) |=> client_ready); // R4

    AST_OOB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx >= COUNT_L) |=> (rd_data == '0)); // R7

    AST_RELEASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && client_ready && release_req) |=> (client_ready && (prod_sel != $past(prod_sel)))); // R8

endmodule

bind ping_pong_frame_buffer pp_frame_checker #(
    .PIX_W     (PIX_W),
    .PIX_COUNT (PIX_COUNT),
    .AW        (AW)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .release_req  (release_req),
    .client_ready (client_ready),
    .prod_sel     (prod_sel),
    .rd_idx       (rd_idx),
    .rd_data      (rd_data)
);

// File: tb/ping_pong_frame_buffer_test.sv
`timescale 1ns/1ps
module ping_pong_frame_buffer_test;

    localparam int PIX   = 1546;
    localparam int AW    = 11;
    localparam int NVEC  = 12;

    typedef struct packed {
        logic        fs;
        logic        rel;
        logic [31:0] t;
        logic        rdy;
        logic        sel;
        logic [31:0] sts;
    } vec_t;

    // Ownership / timestamp vectors (R2 R3 R4 R6 R8)
    localparam vec_t [0:NVEC-1] VECS = '{
        '{1'b1, 1'b0, 32'd100,        1'b1, 1'b1, 32'd0},          // handoff
        '{1'b0, 1'b0, 32'd0,          1'b1, 1'b1, 32'd0},          // idle
        '{1'b1, 1'b0, 32'd300,        1'b1, 1'b1, 32'd0},          // overwrite
        '{1'b0, 1'b1, 32'd0,          1'b0, 1'b1, 32'd0},          // give back
        '{1'b0, 1'b1, 32'd0,          1'b0, 1'b1, 32'd0},          // release ignored
        '{1'b1, 1'b0, 32'd500,        1'b1, 1'b0, 32'd200},        // handoff
        '{1'b1, 1'b1, 32'd701,        1'b1, 1'b1, 32'd400},        // release+frame
        '{1'b1, 1'b0, 32'hFFFF_FFF0,  1'b1, 1'b1, 32'd400},        // overwrite
        '{1'b0, 1'b1, 32'd0,          1'b0, 1'b1, 32'd400},        // give back
        '{1'b1, 1'b0, 32'hFFFF_FFFE,  1'b1, 1'b0, 32'h8000_0156},  // wide sum
        '{1'b0, 1'b1, 32'd0,          1'b0, 1'b0, 32'h8000_0156},  // give back
        '{1'b1, 1'b0, 32'h0000_0010,  1'b1, 1'b1, 32'hFFFF_FFF7}   // wide sum
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic [31:0]   integ_start = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_idx = '0;
    logic [7:0]    wr_data = '0;
    logic          release_req = 1'b0;
    logic          client_ready;
    logic          prod_sel;
    logic [AW-1:0] rd_idx = '0;
    logic [7:0]    rd_data;
    logic [31:0]   stable_ts;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ping_pong_frame_buffer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .integ_start  (integ_start),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .release_req  (release_req),
        .client_ready (client_ready),
        .prod_sel     (prod_sel),
        .rd_idx       (rd_idx),
        .rd_data      (rd_data),
        .stable_ts    (stable_ts)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic fs, input logic rel, input logic [31:0] t);
        frame_start = fs;
        release_req = rel;
        integ_start = t;
        @(negedge clk);
        frame_start = 1'b0;
        release_req = 1'b0;
        integ_start = '0;
    endtask

    task automatic wr(input int idx, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_idx  = AW'(idx);
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int idx, input logic [7:0] exp);
        rd_idx = AW'(idx);
        @(negedge clk);
        chk(req, 32'(rd_data), 32'(exp));
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 8'hFF);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 ready", 32'(client_ready), 32'd0);
        chk("R1 sel", 32'(prod_sel), 32'd0);
        chk("R1 ts", stable_ts, 32'd0);
        chk("R1 rd_data", 32'(rd_data), 32'd0);

        // Vector walk: R2 R3 R4 R6 R8
        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].fs, VECS[i].rel, VECS[i].t);
            chk($sformatf("R4/R2 ready vec %0d", i), 32'(client_ready), 32'(VECS[i].rdy));
            chk($sformatf("R2/R3/R8 sel vec %0d", i), 32'(prod_sel), 32'(VECS[i].sel));
            chk($sformatf("R6 ts vec %0d", i), stable_ts, VECS[i].sts);
        end

        // Data path: R5 R9 R7
        do_reset();
        for (int i = 0; i < PIX; i++) wr(i, pat(i));
        step(1'b1, 1'b0, 32'd10);
        chk("R2 ready after fill", 32'(client_ready), 32'd1);
        rd_chk("R5 first", 0, pat(0));
        rd_chk("R9 second", 1, pat(1));
        rd_chk("R5 middle", 777, pat(777));
        rd_chk("R9 last", PIX - 1, pat(PIX - 1));
        rd_chk("R7 one past", PIX, 8'h00);
        rd_chk("R7 pad", PIX + 1, 8'h00);
        rd_chk("R7 top", 2047, 8'h00);

        // R3: held store, producer overwrites its own
        wr(5, 8'hAA);
        step(1'b1, 1'b0, 32'd20);
        chk("R3 no swap", 32'(prod_sel), 32'd1);
        wr(5, 8'h55);
        rd_chk("R3 stable untouched", 5, pat(5));
        step(1'b0, 1'b1, 32'd0);
        rd_chk("R4 release keeps data", 5, pat(5));
        step(1'b1, 1'b0, 32'd30);
        chk("R2 swap back", 32'(prod_sel), 32'd0);
        rd_chk("R3 overwrite visible", 5, 8'h55);
        // R6 ts: prev 20, T 30 -> store 0 tagged 25; stable is store 1, tagged (10+20)>>1=15
        chk("R6 stable tag", stable_ts, 32'd15);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule